// File: doc/BRIEF.md
# Configurable Priority Encoder

This block watches a set of request lines and, on every clock, reports which of them is active, giving precedence to the lowest-numbered line. What counts as active is set at build time. It can be a steady level of either polarity, or a transition toward that level. In edge mode, a start-up rule says whether the very first sample after reset can already count as a transition. The reported value is either the raw line number or a per-line code taken from a build-time table.

When no line is active, the block normally reports a configured idle code, which defaults to all ones. In hold mode it instead keeps reporting the most recent selection. This gives radio-button behaviour: the last line pressed stays selected until another line takes over. The result is registered, so it is available one clock after the inputs are sampled.

Top module: `prio_sel_enc`

## Requirements
- R1: When several lines are active in the same sample, the reported value belongs to the lowest-numbered of them (line 0 wins over all others).
- R2: With hold mode off and no line active, the output equals the idle code `IDLE_CODE` (default -1, all ones).
- R3: With `ACT_HIGH`=0, a line at 0 is active and a line at 1 is inactive.
- R4: In edge mode, a line is active only in the sample where it moves into the active level; a line resting at the active level is not active.
- R5: In edge mode with `ACT_HIGH`=0, only a 1-to-0 transition makes a line active; a 0-to-1 transition does not.
- R6: With `USE_MAP`=1, the output for line i is the entry `MAP_TABLE[i*OUT_W +: OUT_W]` and not the index i.
- R7: With hold mode on and no line active, the output keeps the last selected value; before any selection since reset, it is the idle code.
- R8: In edge mode with `START_FROM_SAMPLE`=1, the first sample after reset never produces an active line.
- R9: In edge mode with `START_FROM_SAMPLE`=0, the first sample after reset compares each line with the preset level `START_LEVEL`, so a line already at the active level counts as active.
- R10: The output reflects the inputs sampled at a rising clock edge and changes only at that edge, one cycle after the inputs are applied.
- R11: A synchronous reset forces the output to the idle code, clears the held selection and re-arms the start-up rule of R8/R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| req_i | input | N_IN | Request lines, bit i is line i |
| code_o | output | OUT_W | Registered signed result: index, mapped code or idle code |

## Verification
The level-mode instance is driven from a vector table. The table mixes an empty word, single lines at both ends, all lines at once, and sparse multi-bit words, so that a wrong scan direction or a failed idle case gives a different result. An active-low instance with hold enabled alternates between selections and all-inactive words, which separates holding from falling back to the idle code. Two edge instances drive steady levels, rises and falls of each polarity, and a reset while a line is held active, which separates the preset and first-sample start-up rules. A mapped instance uses the codes 1, 10, 100 and 1000, so any leak of the raw index shows up at once.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;

    // Width of an index able to address n lines, never below one bit.
    function automatic int idx_width(input int n);
        int w;
        w = 1;
        while ((1 << w) < n) w++;
        return w;
    endfunction

endpackage

// File: rtl/req_qual.sv
// Turns raw request lines into per-line "active" flags according to
// polarity, level/edge mode and the start-up history rule.
module req_qual #(
    parameter int N_IN              = 8,
    parameter bit ACT_HIGH          = 1'b1,
    parameter bit EDGE_MODE         = 1'b0,
    parameter bit START_FROM_SAMPLE = 1'b1,
    parameter bit START_LEVEL       = 1'b0
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [N_IN-1:0] req_i,
    output logic [N_IN-1:0] act_o
);
    localparam logic START_NORM = ACT_HIGH ? START_LEVEL : ~START_LEVEL;

    typedef struct packed {
        logic [N_IN-1:0] hist;
        logic            init;
    } qual_st_t;

    qual_st_t st_d, st_q;
    logic [N_IN-1:0] lvl;
    logic [N_IN-1:0] prev_lvl;

    always_comb begin
        lvl = ACT_HIGH ? req_i : ~req_i;
        if (st_q.init)
            prev_lvl = st_q.hist;
        else if (START_FROM_SAMPLE)
            prev_lvl = lvl;
        else
            prev_lvl = {N_IN{START_NORM}};
        act_o = EDGE_MODE ? (lvl & ~prev_lvl) : lvl;
        st_d.hist = lvl;
        st_d.init = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.hist <= '0;
            st_q.init <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // An edge-mode line already at the active level last sample is never active now.
    assert_edge_only_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (EDGE_MODE && st_q.init) |-> ((act_o & $past(lvl)) == '0))
        else $error("edge mode reported a resting line");

    // First sample after reset is quiet when history comes from that sample.
    assert_first_quiet_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (EDGE_MODE && START_FROM_SAMPLE && !st_q.init) |-> (act_o == '0))
        else $error("edge on first sample");

endmodule

// File: rtl/prio_find.sv
// Finds the lowest-numbered active line.
module prio_find #(
    parameter int N_IN  = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_IN-1:0]  act_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (act_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    logic [N_IN-1:0] below_mask;
    always_comb begin
        below_mask = (N_IN'(1) << idx_o) - N_IN'(1);
        if (hit_o) begin
            assert_first_R1: assert (act_i[idx_o] && ((act_i & below_mask) == '0))
                else $error("winner is not the lowest active line");
        end
    end

endmodule

// File: rtl/code_map.sv
// Converts a line index into the reported code: raw index or table entry.
module code_map #(
    parameter int                     N_IN      = 8,
    parameter int                     IDX_W     = 3,
    parameter int                     OUT_W     = 8,
    parameter bit                     USE_MAP   = 1'b0,
    parameter logic [N_IN*OUT_W-1:0]  MAP_TABLE = '0
) (
    input  logic [IDX_W-1:0]        idx_i,
    output logic signed [OUT_W-1:0] code_o
);
    generate
        if (USE_MAP) begin : g_table
            logic [OUT_W-1:0] entries [N_IN];
            for (genvar i = 0; i < N_IN; i++) begin : g_ent
                assign entries[i] = MAP_TABLE[i*OUT_W +: OUT_W];
            end
            always_comb begin
                code_o = '0;
                for (int i = 0; i < N_IN; i++) begin
                    if (idx_i == IDX_W'(i)) code_o = entries[i];
                end
            end
        end else begin : g_raw
            assign code_o = OUT_W'(idx_i);
        end
    endgenerate

endmodule

// File: rtl/prio_sel_enc.sv
module prio_sel_enc #(
    parameter int                     N_IN              = 8,
    parameter int                     OUT_W             = 8,
    parameter int                     IDLE_CODE         = -1,
    parameter bit                     ACT_HIGH          = 1'b1,
    parameter bit                     EDGE_MODE         = 1'b0,
    parameter bit                     HOLD_MODE         = 1'b0,
    parameter bit                     START_FROM_SAMPLE = 1'b1,
    parameter bit                     START_LEVEL       = 1'b0,
    parameter bit                     USE_MAP           = 1'b0,
    parameter logic [N_IN*OUT_W-1:0]  MAP_TABLE         = '0
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic [N_IN-1:0]         req_i,
    output logic signed [OUT_W-1:0] code_o
);
    localparam int IDX_W = prio_enc_pkg::idx_width(N_IN);
    localparam logic signed [OUT_W-1:0] IDLE_C = OUT_W'(IDLE_CODE);

    logic [N_IN-1:0]         act;
    logic                    hit;
    logic [IDX_W-1:0]        idx;
    logic signed [OUT_W-1:0] code;

    req_qual #(
        .N_IN(N_IN), .ACT_HIGH(ACT_HIGH), .EDGE_MODE(EDGE_MODE),
        .START_FROM_SAMPLE(START_FROM_SAMPLE), .START_LEVEL(START_LEVEL)
    ) u_qual (
        .clk_i(clk_i), .rst_i(rst_i), .req_i(req_i), .act_o(act)
    );

    prio_find #(.N_IN(N_IN), .IDX_W(IDX_W)) u_find (
        .act_i(act), .hit_o(hit), .idx_o(idx)
    );

    code_map #(
        .N_IN(N_IN), .IDX_W(IDX_W), .OUT_W(OUT_W),
        .USE_MAP(USE_MAP), .MAP_TABLE(MAP_TABLE)
    ) u_map (
        .idx_i(idx), .code_o(code)
    );

    typedef struct packed {
        logic signed [OUT_W-1:0] out;
        logic signed [OUT_W-1:0] held;
    } enc_st_t;

    enc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit) begin
            st_d.out  = code;
            st_d.held = code;
        end else begin
            st_d.out = HOLD_MODE ? st_q.held : IDLE_C;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.out  <= IDLE_C;
            st_q.held <= IDLE_C;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.out;

    assert_idle_code_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!HOLD_MODE && !hit) |=> (code_o == IDLE_C))
        else $error("idle code missing");

    assert_hold_last_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (HOLD_MODE && !hit) |=> $stable(code_o))
        else $error("held selection changed");

    assert_one_cycle_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        hit |=> (code_o == $past(code)))
        else $error("result not registered one cycle later");

    assert_reset_idle_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (code_o == IDLE_C))
        else $error("reset did not load idle code");

endmodule

// File: tb/tb_prio_sel_enc.sv
`timescale 1ns/1ps
module tb_prio_sel_enc;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] req_a = '0;
    logic [3:0] req_b = 4'b1111;
    logic [3:0] req_c = '0;
    logic [3:0] req_d = 4'b0100;
    logic [3:0] req_e = 4'b0000;

    logic signed [7:0]  out_a;
    logic signed [3:0]  out_b;
    logic signed [11:0] out_c;
    logic signed [3:0]  out_d;
    logic signed [3:0]  out_e;

    // Level, active high, no hold, raw index.
    prio_sel_enc dut (.clk_i(clk), .rst_i(rst), .req_i(req_a), .code_o(out_a));

    // Level, active low, hold mode, idle code -3.
    prio_sel_enc #(.N_IN(4), .OUT_W(4), .IDLE_CODE(-3), .ACT_HIGH(1'b0), .HOLD_MODE(1'b1))
        dut_hold (.clk_i(clk), .rst_i(rst), .req_i(req_b), .code_o(out_b));

    // Level, mapped codes 1,10,100,1000.
    prio_sel_enc #(.N_IN(4), .OUT_W(12), .USE_MAP(1'b1),
        .MAP_TABLE({12'd1000, 12'd100, 12'd10, 12'd1}))
        dut_map (.clk_i(clk), .rst_i(rst), .req_i(req_c), .code_o(out_c));

    // Rising edges, history preset to 0.
    prio_sel_enc #(.N_IN(4), .OUT_W(4), .EDGE_MODE(1'b1), .START_FROM_SAMPLE(1'b0),
        .START_LEVEL(1'b0))
        dut_rise (.clk_i(clk), .rst_i(rst), .req_i(req_d), .code_o(out_d));

    // Falling edges, history from first sample.
    prio_sel_enc #(.N_IN(4), .OUT_W(4), .ACT_HIGH(1'b0), .EDGE_MODE(1'b1),
        .START_FROM_SAMPLE(1'b1))
        dut_fall (.clk_i(clk), .rst_i(rst), .req_i(req_e), .code_o(out_e));

    // {request, expected signed code}
    localparam logic [15:0] VEC [8] = '{
        {8'h00, 8'hFF}, {8'h01, 8'h00}, {8'h80, 8'h07}, {8'hFF, 8'h00},
        {8'h0C, 8'h02}, {8'hA0, 8'h05}, {8'h40, 8'h06}, {8'h00, 8'hFF}
    };

    task automatic check(input int got, input int exp, input string req);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Apply inputs away from the edge, then look just after the next rising edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R11: reset holds every instance at its idle code
        repeat (3) @(negedge clk);
        check(out_a, -1, "R11");
        check(out_b, -3, "R11");
        check(out_d, -1, "R11");

        @(negedge clk);
        rst = 1'b0;
        step();
        check(out_d, 2, "R9");   // line 2 already high vs preset 0
        check(out_e, -1, "R8");  // all low but first sample is quiet
        check(out_b, -3, "R7");  // nothing selected yet

        // Level table, R1/R2
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            req_a = VEC[i][15:8];
            step();
            check(out_a, int'($signed(VEC[i][7:0])), (VEC[i][7:0] == 8'hFF) ? "R2" : "R1");
        end

        // R10: no change before the edge
        @(negedge clk);
        req_a = 8'h10;
        #1;
        check(out_a, -1, "R10");
        step();
        check(out_a, 4, "R10");

        // Active-low with hold: R3, R7
        @(negedge clk); req_b = 4'b1011; step(); check(out_b, 2, "R3");
        @(negedge clk); req_b = 4'b1111; step(); check(out_b, 2, "R7");
        @(negedge clk); req_b = 4'b0110; step(); check(out_b, 0, "R3");
        @(negedge clk); req_b = 4'b1111; step(); check(out_b, 0, "R7");

        // Map: R6
        @(negedge clk); req_c = 4'b0100; step(); check(out_c, 100, "R6");
        @(negedge clk); req_c = 4'b1000; step(); check(out_c, 1000, "R6");
        @(negedge clk); req_c = 4'b0011; step(); check(out_c, 1, "R6");
        @(negedge clk); req_c = 4'b0000; step(); check(out_c, -1, "R2");

        // Rising edges: R4 (req_d has rested at 0100 for many cycles)
        check(out_d, -1, "R4");
        @(negedge clk); req_d = 4'b0101; step(); check(out_d, 0, "R4");
        @(negedge clk); req_d = 4'b0001; step(); check(out_d, -1, "R4");
        @(negedge clk); req_d = 4'b1001; step(); check(out_d, 3, "R4");

        // Falling edges: R5
        @(negedge clk); req_e = 4'b0010; step(); check(out_e, -1, "R5");
        @(negedge clk); req_e = 4'b0000; step(); check(out_e, 1, "R5");
        @(negedge clk); req_e = 4'b1111; step(); check(out_e, -1, "R5");

        // R11: reset clears the hold and re-arms the start-up rule
        @(negedge clk);
        rst = 1'b1;
        req_d = 4'b0100;
        req_b = 4'b1111;
        step();
        check(out_b, -3, "R11");
        @(negedge clk);
        rst = 1'b0;
        step();
        check(out_d, 2, "R11");
        check(out_b, -3, "R11");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule